// File: doc/BRIEF.md
# Serial-In Latched Parallel Output Driver

This block turns a serial bit stream into a set of parallel channel levels for display column or row drivers. A chain of shift stages collects bits one at a time, one bit on each rising edge of a shift clock. A holding register then takes a copy of that chain on command. A gate decides whether the held copy reaches the channel pins or all channels are held low. A serial cascade output shows the bit at the far end of the chain, so several devices can be daisy-chained from one data source.

All logic runs on a single system clock. The shift clock is an ordinary input that is sampled and edge-detected. The holding register loads on every system-clock edge while latch-enable is high, which makes it behave as if it were transparent. A direction input selects which end of the chain receives new data.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift chain and the holding register, so after reset every channel output and the cascade output read 0.
- R2: The chain advances by exactly one stage on each low-to-high transition of `shift_clk`, as seen at a system-clock edge. While `shift_clk` stays high or stays low, the chain does not move. After reset, `shift_clk` must be seen low before a rise counts.
- R3: With `rev` = 0, a new bit enters stage 1 (`chan_out[0]`) and every stage moves up one index. `sdo` shows stage N (`chan_out[N-1]` after a latch).
- R4: With `rev` = 1, a new bit enters stage N (index N-1) and every stage moves down one index. `sdo` shows stage 1 (index 0).
- R5: While `le` is high at a system-clock edge, the holding register takes the chain contents as they stood before that edge. If a shift happens on the same edge, the register captures the pre-shift values.
- R6: While `le` is low, the holding register keeps its value, and shifting continues freely.
- R7: With `oe` low, all channel outputs are 0 whatever is held. With `oe` high, each channel output equals its held bit.
- R8: `le` and `oe` have no effect on shifting or on `sdo`.
- R9: In forward mode, a bit presented at `sdi` appears on `sdo` after exactly N shift-clock rises. This lets the next device in a chain receive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Shift clock level; the chain advances on its rise |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch enable level |
| oe | input | 1 | Output enable level; low forces channels to 0 |
| rev | input | 1 | Shift direction: 0 forward, 1 reverse |
| chan_out | output | N | Parallel channel outputs |
| sdo | output | 1 | Serial cascade output |

## Verification
The case that is hardest to reach is a latch and a shift landing on the same system-clock edge. The stimulus reaches it by raising `le` in exactly the cycle in which `shift_clk` rises, and checking that the channels then show the pre-shift pattern. It also drives a full N-bit frame through in reverse mode and keeps `shift_clk` high for several cycles, which shows that only rises advance the chain. `le` and `oe` are toggled during shifting to show that `sdo` does not depend on them.

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_clk,
  input  logic         sdi,
  input  logic         le,
  input  logic         oe,
  input  logic         rev,
  output logic [N-1:0] chan_out,
  output logic         sdo
);

  logic [N-1:0] sr_q;
  logic [N-1:0] lat_q;
  logic         sclk_q;
  logic         rise;

  assign rise = shift_clk & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      lat_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= shift_clk;
      if (le) lat_q <= sr_q;
      if (rise) sr_q <= rev ? {sdi, sr_q[N-1:1]} : {sr_q[N-2:0], sdi};
    end
  end

  assign chan_out = oe ? lat_q : '0;
  assign sdo      = rev ? sr_q[0] : sr_q[N-1];

endmodule

// File: rtl/serial_latch_driver_chk.sv
module serial_latch_driver_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_clk,
  input logic         sdi,
  input logic         le,
  input logic         oe,
  input logic         rev,
  input logic [N-1:0] chan_out,
  input logic         sdo,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] lat_q
);

  logic prev_sclk;
  logic seen_rise;

  always_ff @(posedge clk) begin
    if (rst) prev_sclk <= 1'b1;
    else     prev_sclk <= shift_clk;
  end

  assign seen_rise = shift_clk & ~prev_sclk;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (chan_out == '0 && sdo == 1'b0));

  assert_hold_still_R2: assert property (@(posedge clk) disable iff (rst)
    !seen_rise |=> $stable(sr_q));

  assert_fwd_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_rise && !rev) |=> (sr_q[N-1:1] == $past(sr_q[N-2:0]) && sr_q[0] == $past(sdi)));

  assert_rev_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_rise && rev) |=> (sr_q[N-2:0] == $past(sr_q[N-1:1]) && sr_q[N-1] == $past(sdi)));

  assert_latch_load_R5: assert property (@(posedge clk) disable iff (rst)
    le |=> lat_q == $past(sr_q));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(lat_q));

  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    le |=> (oe ? chan_out == $past(sr_q) : chan_out == '0));

endmodule

bind serial_latch_driver serial_latch_driver_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .shift_clk(shift_clk), .sdi(sdi), .le(le), .oe(oe),
  .rev(rev), .chan_out(chan_out), .sdo(sdo), .sr_q(sr_q), .lat_q(lat_q)
);

// File: tb/serial_latch_driver_tb.sv
module serial_latch_driver_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk = 1'b0, sdi = 1'b0, le = 1'b0, oe = 1'b0, rev = 1'b0;
  logic [N-1:0] chan_out;
  logic sdo;

  always #5 clk = ~clk;

  serial_latch_driver #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .sdi(sdi), .le(le), .oe(oe),
    .rev(rev), .chan_out(chan_out), .sdo(sdo)
  );

  typedef struct {
    logic [N-1:0] chan;
    logic         so;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [N-1:0] m_sr = '0, m_lat = '0;
  logic m_prev = 1'b1;

  // Monitor: compares every queued item shortly after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        tests++;
        if (chan_out !== e.chan || sdo !== e.so) begin
          fails++;
          $display("FAIL %s: chan=%h sdo=%b expected chan=%h sdo=%b",
                   e.tag, chan_out, sdo, e.chan, e.so);
        end
      end
    end
  end

  task automatic push(input string tag);
    exp_t e;
    e.chan = oe ? m_lat : '0;
    e.so   = rev ? m_sr[0] : m_sr[N-1];
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Driver: apply inputs for one system clock, advance the model, queue expectation
  task automatic step(input logic sc, input logic d, input logic l, input logic o,
                      input logic r, input string tag);
    logic rs;
    shift_clk = sc; sdi = d; le = l; oe = o; rev = r;
    rs = sc & ~m_prev;
    if (l) m_lat = m_sr;
    if (rs) m_sr = r ? {d, m_sr[N-1:1]} : {m_sr[N-2:0], d};
    m_prev = sc;
    @(negedge clk);
    push(tag);
    #3;
  endtask

  task automatic shift_bit(input logic d, input logic l, input logic o,
                           input logic r, input string tag);
    step(1'b0, d, l, o, r, tag);
    step(1'b1, d, l, o, r, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);
    #3;
    rst = 1'b0;
    oe = 1'b1;
    m_prev = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1 reset state");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 held high no shift");

    pat = 32'hA5C3_0F96;
    for (int i = N - 1; i >= 0; i--) shift_bit(pat[i], 1'b0, 1'b1, 1'b0, "R3 R6 forward fill");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5 load forward frame");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 forward frame shown");

    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 held high stable");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 held low stable");

    for (int i = 0; i < 6; i++) shift_bit(i[0], i[1], 1'b0, 1'b0, "R7 R8 oe low gate");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 oe high shows latch");

    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 prep");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 same edge pre-shift capture");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 capture held");

    shift_bit(1'b1, 1'b0, 1'b1, 1'b0, "R9 marker in");
    for (int i = 1; i < N; i++) shift_bit(1'b0, i[2], i[3], 1'b0, "R8 R9 cascade walk");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 marker at sdo");

    pat = 32'h1234_8001;
    for (int i = 0; i < N; i++) shift_bit(pat[i], 1'b0, 1'b1, 1'b1, "R4 reverse fill");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4 R5 load reverse frame");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 reverse frame shown");
    for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b0, 1'b1, 1'b1, "R4 R6 reverse hold");

    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 pre reset");
    rst = 1'b1;
    m_sr = '0; m_lat = '0; m_prev = 1'b1;
    @(negedge clk);
    push("R1 reset clears");
    #3;
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1 R2 no rise after reset");

    @(negedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule